// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts activity for a processor core. It has three counters. A cycle counter runs either on every clock or on every 64th clock. Two event counters each follow one line of an event input vector, and an 8-bit code chooses that line. All of the configuration sits in one 32-bit control word. That word holds the two event codes, a global run bit, the prescaler choice, an interrupt enable for each counter, an event-export enable and the sticky overflow flags. The same word carries two self-clearing bits that zero the counters.

Software reaches the control word and all three counters over one plain register port. The port has a write strobe, a 2-bit address, write data, and read data that follows the address in the same cycle. Two signals leave the block. The interrupt request is raised while any overflow flag is set and its enable is on. The export bus copies the event vector to an external trace monitor, or reads as zero while export is off. The port has no handshake, so a write completes on the clock edge that samples it and the port never applies back-pressure.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, every register reads 0, `irq` is low and `evt_out` is all zeros.
- R2: Control word layout: [27:20] is the event code for counter 0, [19:12] the event code for counter 1, [11] export enable, [6] cycle-counter interrupt enable, [5] counter-1 interrupt enable, [4] counter-0 interrupt enable, [3] divide-by-64 select and [0] global run. Bits [31:28] and [7] ignore writes and read as 0.
- R3: `evt_out` equals `evt_in` while export is enabled, and is all zeros otherwise.
- R4: No counter advances while the run bit is 0.
- R5: When run is 1, an event counter adds one on each clock where its selected `evt_in` line is 1. A code of `NUM_EVT` or above selects a constant 0.
- R6: When run is 1 and divide is 0, the cycle counter adds one every clock. When divide is 1, it adds one on every 64th clock on which run is 1. A 6-bit prescaler advances on each clock where run is 1. The counter steps when the prescaler is at 63, and the prescaler then wraps to 0.
- R7: A counter that steps from all ones to zero sets its overflow flag: bit 10 for the cycle counter, bit 9 for counter 1 and bit 8 for counter 0. The flag reads 1 from the next cycle.
- R8: Writing a 1 to a flag bit in the control word clears that flag, and writing a 0 leaves it unchanged. If a wrap and a clear fall in the same cycle, the flag stays set.
- R9: `irq` is the OR, over the three counters, of each overflow flag ANDed with its enable. It stays high until software clears the flags or the enables.
- R10: Writing a 1 to control bit 1 zeroes both event counters. Writing a 1 to bit 2 zeroes the cycle counter and the prescaler. Both bits read as 0.
- R11: Address 0 selects the control word, 1 the cycle counter, 2 event counter 0 and 3 event counter 1. A write to a counter loads it and takes priority over an increment in the same cycle, and that load never sets a flag.
- R12: `reg_rdata` shows the register at `reg_addr` in the same cycle, without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| evt_in | input | NUM_EVT | Event lines from the core |
| evt_out | output | NUM_EVT | Gated event lines for the trace monitor |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench preloads counters close to all ones so that each counter wraps within a few clocks. One case lets a wrap land in the same cycle as a write-one-clear. A design that gave priority to the clear would lose that overflow and drop `irq`. Divide mode runs for several hundred clocks, with the run bit toggled, so that a prescaler that ignored run, or never reset, shows up as a drifting cycle count. An out-of-range event code, writes to the reserved bits, and a counter load in a cycle with an increment check for a stray count, for reserved bits that stick, and for a lost load.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CYC  = 2'd1,
    ADDR_EV0  = 2'd2,
    ADDR_EV1  = 2'd3
  } pmu_addr_e;

  localparam int B_RUN    = 0;
  localparam int B_ZEV    = 1;
  localparam int B_ZCY    = 2;
  localparam int B_DIV    = 3;
  localparam int B_IEN_LO = 4;
  localparam int B_OVF_LO = 8;
  localparam int B_EXP    = 11;
  localparam int B_SEL1   = 12;
  localparam int B_SEL0   = 20;

  // ovf and ien are indexed 0 = event counter 0, 1 = event counter 1, 2 = cycle counter
  typedef struct packed {
    logic [7:0] sel0;
    logic [7:0] sel1;
    logic       exp_en;
    logic [2:0] ovf;
    logic [2:0] ien;
    logic       div64;
    logic       run;
  } pmu_ctrl_t;

  function automatic logic [REG_W-1:0] ctrl_word(pmu_ctrl_t c);
    return {4'h0, c.sel0, c.sel1, c.exp_en, c.ovf, 1'b0, c.ien, c.div64, 2'b00, c.run};
  endfunction

endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);

  assign wrap = inc & ~clr & ~ld & (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (ld)  cnt <= ld_val;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + W'(1);
  end

  // R11
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt == $past(ld_val));

  // R10
  zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ld) |=> cnt == '0);

  // R5
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && !ld) |=> cnt == $past(cnt) + W'(1));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr && !ld) |=> $stable(cnt));

endmodule

// File: rtl/pmu_prescaler.sv
module pmu_prescaler #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic tick
);

  localparam int PW = $clog2(DIV);
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pcnt;

  assign tick = en & (pcnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pcnt <= '0;
    else if (clr) pcnt <= '0;
    else if (en)  pcnt <= (pcnt == LAST) ? '0 : pcnt + PW'(1);
  end

  // R6
  clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !tick);

  // R6
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/pmu_event_sel.sv
module pmu_event_sel #(
  parameter int NUM_EVT = 32,
  parameter int SEL_W   = 8
) (
  input  logic [NUM_EVT-1:0] evt,
  input  logic [SEL_W-1:0]   sel,
  output logic               hit
);

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (sel == SEL_W'(i)) hit = evt[i];
    end
  end

endmodule

// File: rtl/pmu_ctrl_reg.sv
module pmu_ctrl_reg
  import pmu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic [2:0]       ovf_set,
  output pmu_ctrl_t        ctrl,
  output logic             zero_ev,
  output logic             zero_cy,
  output logic [REG_W-1:0] rdata
);

  logic [2:0] w1c;
  logic       unused_rsvd;

  assign unused_rsvd = ^{wdata[31:28], wdata[7]};
  assign w1c     = wr ? wdata[B_OVF_LO +: 3] : 3'b000;
  assign zero_ev = wr & wdata[B_ZEV];
  assign zero_cy = wr & wdata[B_ZCY];
  assign rdata   = ctrl_word(ctrl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else begin
      if (wr) begin
        ctrl.sel0   <= wdata[B_SEL0 +: 8];
        ctrl.sel1   <= wdata[B_SEL1 +: 8];
        ctrl.exp_en <= wdata[B_EXP];
        ctrl.ien    <= wdata[B_IEN_LO +: 3];
        ctrl.div64  <= wdata[B_DIV];
        ctrl.run    <= wdata[B_RUN];
      end
      ctrl.ovf <= (ctrl.ovf & ~w1c) | ovf_set;
    end
  end

  // R7
  set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_set != 3'b000) |=> ((ctrl.ovf & $past(ovf_set)) == $past(ovf_set)));

  // R8
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> ((ctrl.ovf & $past(wdata[B_OVF_LO +: 3] & ~ovf_set)) == 3'b000));

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ((ctrl.ovf & $past(ctrl.ovf)) == $past(ctrl.ovf)));

endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int NUM_EVT = 32,
  parameter int CNT_W   = 32,
  parameter int DIV     = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic [NUM_EVT-1:0] evt_in,
  output logic [NUM_EVT-1:0] evt_out,
  output logic               irq
);

  localparam int NUM_EV_CNT = 2;

  pmu_ctrl_t          ctrl;
  logic [REG_W-1:0]   ctrl_rd;
  logic               zero_ev, zero_cy;
  logic               wr_ctrl, wr_cyc;
  logic [CNT_W-1:0]   ev_cnt [NUM_EV_CNT];
  logic [NUM_EV_CNT-1:0] ev_wrap;
  logic [CNT_W-1:0]   cyc_cnt;
  logic               cyc_wrap, cyc_inc, pre_tick;

  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_cyc  = reg_wr && (reg_addr == ADDR_CYC);

  pmu_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (wr_ctrl),
    .wdata   (reg_wdata),
    .ovf_set ({cyc_wrap, ev_wrap}),
    .ctrl    (ctrl),
    .zero_ev (zero_ev),
    .zero_cy (zero_cy),
    .rdata   (ctrl_rd)
  );

  for (genvar g = 0; g < NUM_EV_CNT; g++) begin : g_ev
    localparam logic [1:0] MY_ADDR = 2'(int'(ADDR_EV0) + g);
    logic [7:0] sel;
    logic       hit;

    assign sel = (g == 0) ? ctrl.sel0 : ctrl.sel1;

    pmu_event_sel #(.NUM_EVT(NUM_EVT), .SEL_W(8)) u_sel (
      .evt (evt_in),
      .sel (sel),
      .hit (hit)
    );

    pmu_counter #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (ctrl.run & hit),
      .clr    (zero_ev),
      .ld     (reg_wr && (reg_addr == MY_ADDR)),
      .ld_val (reg_wdata[CNT_W-1:0]),
      .cnt    (ev_cnt[g]),
      .wrap   (ev_wrap[g])
    );
  end

  pmu_prescaler #(.DIV(DIV)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (ctrl.run),
    .clr   (zero_cy),
    .tick  (pre_tick)
  );

  assign cyc_inc = ctrl.run & (ctrl.div64 ? pre_tick : 1'b1);

  pmu_counter #(.W(CNT_W)) u_cyc (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (cyc_inc),
    .clr    (zero_cy),
    .ld     (wr_cyc),
    .ld_val (reg_wdata[CNT_W-1:0]),
    .cnt    (cyc_cnt),
    .wrap   (cyc_wrap)
  );

  always_comb begin
    unique case (reg_addr)
      ADDR_CTRL: reg_rdata = ctrl_rd;
      ADDR_CYC:  reg_rdata = REG_W'(cyc_cnt);
      ADDR_EV0:  reg_rdata = REG_W'(ev_cnt[0]);
      default:   reg_rdata = REG_W'(ev_cnt[1]);
    endcase
  end

  assign evt_out = ctrl.exp_en ? evt_in : '0;
  assign irq     = |(ctrl.ovf & ctrl.ien);

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !reg_wr) |=> irq);

  // R4
  run_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !reg_wr) |=> ($stable(cyc_cnt) && $stable(ev_cnt[0]) && $stable(ev_cnt[1])));

  // R7
  no_load_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cyc && !ctrl.ovf[2]) |=> !ctrl.ovf[2]);

endmodule

// File: tb/tb_perf_mon_unit.sv
module tb_perf_mon_unit;

  localparam int NUM_EVT = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NUM_EVT-1:0] evt_in = '0;
  logic [NUM_EVT-1:0] evt_out;
  logic irq;

  always #10 clk = ~clk;

  perf_mon_unit #(.NUM_EVT(NUM_EVT), .CNT_W(32), .DIV(64)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
    .evt_out(evt_out), .irq(irq)
  );

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural reference state
  bit m_run, m_div, m_exp;
  bit [2:0] m_ie, m_ovf;
  int m_sel0, m_sel1, m_pre;
  logic [31:0] m_cyc, m_c0, m_c1;
  bit rand_ev = 0;
  logic [31:0] lfsr = 32'h1;

  function automatic logic [31:0] cw(bit run, bit div, bit [2:0] ie, bit ex,
                                     bit [7:0] s0, bit [7:0] s1, bit [2:0] w1c,
                                     bit zev, bit zcy);
    return {4'h0, s0, s1, ex, w1c, 1'b0, ie, div, zcy, zev, run};
  endfunction

  function automatic logic [31:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return {4'h0, 8'(m_sel0), 8'(m_sel1), m_exp, m_ovf, 1'b0, m_ie, m_div, 2'b00, m_run};
      2'd1: return m_cyc;
      2'd2: return m_c0;
      default: return m_c1;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R9 irq", 32'(irq), 32'(|(m_ovf & m_ie)));
    check("R3 evt_out", evt_out, m_exp ? evt_in : '0);
    check(reg_addr == 0 ? "R2 ctrl read" : "R12 counter read", reg_rdata, m_read(reg_addr));
  endtask

  task automatic tick();
    bit wc, h0, h1, ctick;
    bit [2:0] set, clr;
    logic [31:0] n_c0, n_c1, n_cyc;
    int n_pre;
    wc = reg_wr && reg_addr == 0;
    h0 = (m_sel0 < NUM_EVT) ? evt_in[m_sel0] : 1'b0;
    h1 = (m_sel1 < NUM_EVT) ? evt_in[m_sel1] : 1'b0;
    ctick = m_run && (!m_div || m_pre == 63);
    set = 3'b000;
    n_c0 = m_c0; n_c1 = m_c1; n_cyc = m_cyc; n_pre = m_pre;
    if (reg_wr && reg_addr == 2) n_c0 = reg_wdata;
    else if (wc && reg_wdata[1]) n_c0 = 0;
    else if (m_run && h0) begin n_c0 = m_c0 + 1; if (m_c0 == 32'hFFFF_FFFF) set[0] = 1; end
    if (reg_wr && reg_addr == 3) n_c1 = reg_wdata;
    else if (wc && reg_wdata[1]) n_c1 = 0;
    else if (m_run && h1) begin n_c1 = m_c1 + 1; if (m_c1 == 32'hFFFF_FFFF) set[1] = 1; end
    if (reg_wr && reg_addr == 1) n_cyc = reg_wdata;
    else if (wc && reg_wdata[2]) n_cyc = 0;
    else if (ctick) begin n_cyc = m_cyc + 1; if (m_cyc == 32'hFFFF_FFFF) set[2] = 1; end
    if (wc && reg_wdata[2]) n_pre = 0;
    else if (m_run) n_pre = (m_pre + 1) % 64;
    clr = wc ? reg_wdata[10:8] : 3'b000;
    @(posedge clk);
    m_c0 = n_c0; m_c1 = n_c1; m_cyc = n_cyc; m_pre = n_pre;
    m_ovf = (m_ovf & ~clr) | set;
    if (wc) begin
      m_sel0 = int'(reg_wdata[27:20]); m_sel1 = int'(reg_wdata[19:12]);
      m_exp = reg_wdata[11]; m_ie = reg_wdata[6:4]; m_div = reg_wdata[3]; m_run = reg_wdata[0];
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      if (rand_ev) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        evt_in = lfsr;
      end
      tick();
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic peek(logic [1:0] a, string tag);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, m_read(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    m_run = 0; m_div = 0; m_exp = 0; m_ie = 0; m_ovf = 0;
    m_sel0 = 0; m_sel1 = 0; m_pre = 0; m_cyc = 0; m_c0 = 0; m_c1 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 4; a++) peek(2'(a), "R1 reset read");
    check("R1 irq", 32'(irq), 0);
    check("R1 evt_out", evt_out, 0);

    // R2 R5 reserved bits, out-of-range code 200, random events, export on
    rand_ev = 1;
    wr(2'd0, cw(1, 0, 3'b000, 1, 8'd3, 8'd200, 0, 0, 0) | 32'hF000_0080);
    peek(2'd0, "R2 reserved bits read 0");
    idle(60);
    peek(2'd2, "R5 counter 0");
    peek(2'd3, "R5 out-of-range code");
    peek(2'd1, "R6 cycle count");

    // R4 run off
    wr(2'd0, cw(0, 0, 3'b000, 1, 8'd3, 8'd5, 0, 0, 0));
    idle(20);
    peek(2'd1, "R4 frozen cycle count");

    // R6 divide by 64, export off (R3), with a run pause
    wr(2'd0, cw(1, 1, 3'b000, 0, 8'd3, 8'd5, 0, 0, 0));
    idle(150);
    wr(2'd0, cw(0, 1, 3'b000, 0, 8'd3, 8'd5, 0, 0, 0));
    idle(10);
    wr(2'd0, cw(1, 1, 3'b000, 0, 8'd3, 8'd5, 0, 0, 0));
    idle(150);
    peek(2'd1, "R6 divided cycle count");

    // R7 R9 counter 0 wrap with steady events
    rand_ev = 0; evt_in = '1;
    wr(2'd0, cw(1, 0, 3'b111, 1, 8'd7, 8'd9, 0, 0, 0));
    wr(2'd2, 32'hFFFF_FFF0);
    idle(20);
    peek(2'd0, "R7 flag after counter 0 wrap");
    check("R9 irq after wrap", 32'(irq), 1);

    // R8 write zero no effect, then clear
    wr(2'd0, cw(1, 0, 3'b111, 1, 8'd7, 8'd9, 3'b000, 0, 0));
    peek(2'd0, "R8 write 0 keeps flag");
    wr(2'd0, cw(1, 0, 3'b111, 1, 8'd7, 8'd9, 3'b011, 0, 0));
    peek(2'd0, "R8 write 1 clears flag");

    // R8 set wins over clear in the same cycle
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd0, cw(1, 0, 3'b111, 1, 8'd7, 8'd9, 3'b001, 0, 0));
    peek(2'd0, "R8 set beats clear");
    check("R8 irq kept", 32'(irq), 1);

    // R7 cycle counter wrap
    wr(2'd1, 32'hFFFF_FFF8);
    idle(12);
    peek(2'd0, "R7 cycle flag");

    // R11 load beats increment
    wr(2'd3, 32'h0000_0005);
    peek(2'd3, "R11 load wins");
    idle(3);

    // R10 zeroing bits
    wr(2'd0, cw(1, 0, 3'b111, 1, 8'd7, 8'd9, 3'b000, 1, 0));
    peek(2'd0, "R10 self-clear read");
    peek(2'd2, "R10 event counters zeroed");
    wr(2'd0, cw(1, 1, 3'b111, 1, 8'd7, 8'd9, 3'b000, 0, 1));
    peek(2'd1, "R10 cycle counter zeroed");
    idle(70);
    peek(2'd1, "R10 prescaler restarted");

    // R9 clear everything
    wr(2'd0, cw(0, 0, 3'b111, 0, 8'd7, 8'd9, 3'b111, 0, 0));
    check("R9 irq after clear", 32'(irq), 0);
    idle(4);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule